// File: doc/BRIEF.md
# Timer Clock Source Selector

This block decides, on every system clock, whether a timer downstream should advance. A 3-bit select code chooses the source. One code holds the timer still. One code advances it on every clock. Four codes advance it at fixed fractions of the clock rate, and the last two advance it once per falling or once per rising transition of an external input pin. The result is a single registered count-enable output. Each time the chosen source fires, that output is high for exactly one system clock.

A free-running 10-bit prescale counter sits inside the block and runs whatever the select code is. The four divided rates are taken from it, so they always come straight from the system clock. The external pin is asynchronous to the system clock. It passes through a two-flop synchroniser, and then a stage that remembers its previous value detects the edges. A new select code is used from the next clock edge. Changing the code never disturbs the prescale counter or the synchroniser.

Top module: `timer_clk_sel`

## Requirements
- R1: With select code 000, `cntEn` stays low on every cycle.
- R2: With select code 001, `cntEn` is high after every clock edge.
- R3: With select code 010, 011, 100 or 101, `cntEn` is high after an edge exactly when the prescale count at that edge is a multiple of 8, 64, 256 or 1024 respectively, giving one-cycle pulses at those periods.
- R4: The prescale count is 0 at the first edge after reset and increases by one on every edge, wrapping at 1024. A change of select code never clears it.
- R5: With select code 110, `cntEn` pulses for one cycle per falling transition of `extPin`. With 111, it pulses once per rising transition. The pulse follows the third clock edge after the pin change.
- R6: The pin synchroniser and the edge memory run in every mode, so a pin change made under another code is seen with the same latency once an external code is chosen.
- R7: `cntEn` after an edge depends only on the select code sampled at that edge. A new code takes effect on the next edge.
- R8: While `rstN` is low, `cntEn` is low, the prescale count is 0 and the synchroniser holds 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcSel | input | 3 | Count source select code |
| extPin | input | 1 | External count pin, asynchronous |
| cntEn | output | 1 | Registered one-cycle count enable |

## Verification
For the stop code, the every-clock code and the divided codes, the result belongs to the edge at which the code and the prescale count were sampled. It is due one clock edge after the inputs are driven. For the external codes, it is due on the third edge after the pin is driven. The driver task drives the inputs at the falling clock edge and pushes one expectation for the coming rising edge. It computes that expectation from the select code, its own count of edges since reset and a three-deep history of the pin values it drove. The monitor pops the expectation one time unit after the rising edge and compares it with `cntEn`, so every comparison lines up with the edge that produced the result.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

  localparam int NUM_TAPS = 4;
  localparam int TAP_LOG2 [NUM_TAPS] = '{3, 6, 8, 10};
  localparam int PRE_W = TAP_LOG2[NUM_TAPS-1];

  typedef enum logic [2:0] {
    SRC_STOP     = 3'b000,
    SRC_SYS      = 3'b001,
    SRC_DIV8     = 3'b010,
    SRC_DIV64    = 3'b011,
    SRC_DIV256   = 3'b100,
    SRC_DIV1024  = 3'b101,
    SRC_PIN_FALL = 3'b110,
    SRC_PIN_RISE = 3'b111
  } tcs_src_e;

  typedef struct packed {
    logic                sysTick;
    logic [NUM_TAPS-1:0] tapTick;
    logic                pinFall;
    logic                pinRise;
  } tcs_strobe_t;

endpackage

// File: rtl/tcs_prescaler.sv
module tcs_prescaler
  import tcs_pkg::*;
#(
  parameter int CNT_W = PRE_W
) (
  input  logic                clk,
  input  logic                rstN,
  output logic [NUM_TAPS-1:0] tapTick
);

  logic [CNT_W-1:0] preCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    localparam int LowBits = TAP_LOG2[t];
    assign tapTick[t] = (preCnt[LowBits-1:0] == '0);
  end

endmodule

// File: rtl/tcs_pin_sync.sv
module tcs_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic extPin,
  output logic pinFall,
  output logic pinRise
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   pinStable;
  logic                   pinLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '0;
      pinLast <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], extPin};
      pinLast <= pinStable;
    end
  end

  assign pinStable = syncQ[SYNC_STAGES-1];
  assign pinFall   = pinLast & ~pinStable;
  assign pinRise   = ~pinLast & pinStable;

endmodule

// File: rtl/tcs_datapath.sv
module tcs_datapath
  import tcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        extPin,
  output tcs_strobe_t strobes
);

  logic [NUM_TAPS-1:0] tapTick;
  logic                pinFall;
  logic                pinRise;

  tcs_prescaler #(.CNT_W(PRE_W)) u_pre (
    .clk    (clk),
    .rstN   (rstN),
    .tapTick(tapTick)
  );

  tcs_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .extPin (extPin),
    .pinFall(pinFall),
    .pinRise(pinRise)
  );

  always_comb begin
    strobes.sysTick = 1'b1;
    strobes.tapTick = tapTick;
    strobes.pinFall = pinFall;
    strobes.pinRise = pinRise;
  end

endmodule

// File: rtl/tcs_control.sv
module tcs_control
  import tcs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  srcSel,
  input  tcs_strobe_t strobes,
  output logic        cntEn
);

  logic pickNext;

  always_comb begin
    case (tcs_src_e'(srcSel))
      SRC_STOP:     pickNext = 1'b0;
      SRC_SYS:      pickNext = strobes.sysTick;
      SRC_DIV8:     pickNext = strobes.tapTick[0];
      SRC_DIV64:    pickNext = strobes.tapTick[1];
      SRC_DIV256:   pickNext = strobes.tapTick[2];
      SRC_DIV1024:  pickNext = strobes.tapTick[3];
      SRC_PIN_FALL: pickNext = strobes.pinFall;
      SRC_PIN_RISE: pickNext = strobes.pinRise;
      default:      pickNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cntEn <= 1'b0;
    else       cntEn <= pickNext;
  end

endmodule

// File: rtl/timer_clk_sel.sv
module timer_clk_sel
  import tcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] srcSel,
  input  logic       extPin,
  output logic       cntEn
);

  tcs_strobe_t strobes;

  tcs_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .extPin (extPin),
    .strobes(strobes)
  );

  tcs_control u_ctl (
    .clk    (clk),
    .rstN   (rstN),
    .srcSel (srcSel),
    .strobes(strobes),
    .cntEn  (cntEn)
  );

endmodule

// File: rtl/tcs_checker.sv
module tcs_checker (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] srcSel,
  input logic       cntEn
);

  logic        armed;
  logic [10:0] gap;
  logic [3:0]  held;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
      gap   <= '0;
      held  <= '0;
    end else begin
      armed <= 1'b1;
      if (cntEn)             gap <= 11'd1;
      else if (gap != '1)    gap <= gap + 1'b1;
      if (srcSel != 3'b010)  held <= '0;
      else if (held != '1)   held <= held + 1'b1;
    end
  end

  assert_stop_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(srcSel) == 3'b000) |-> !cntEn);

  assert_sys_every_R2: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(srcSel) == 3'b001) |-> cntEn);

  assert_div8_spacing_R3: assert property (@(posedge clk) disable iff (!rstN)
    (armed && cntEn && $past(srcSel) == 3'b010 && held >= 4'd9) |-> gap == 11'd8);

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    (armed && cntEn && $past(srcSel) >= 3'b010 && srcSel == $past(srcSel)) |=> !cntEn);

endmodule

bind timer_clk_sel tcs_checker u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .srcSel(srcSel),
  .cntEn (cntEn)
);

// File: tb/tb_timer_clk_sel.sv
module tb_timer_clk_sel;

  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] srcSel = 3'b000;
  logic       extPin = 1'b0;
  logic       cntEn;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic  expQ [$];
  string tagQ [$];

  int         edgeCnt = 0;
  logic       h1 = 1'b0, h2 = 1'b0, h3 = 1'b0;
  logic [2:0] lastSel = 3'b000;

  timer_clk_sel dut (
    .clk   (clk),
    .rstN  (rstN),
    .srcSel(srcSel),
    .extPin(extPin),
    .cntEn (cntEn)
  );

  always #(PERIOD/2) clk = ~clk;

  // Called at a falling edge: drive, push expectation for the coming rising edge.
  task automatic step(input logic [2:0] sel, input logic pin);
    logic  e;
    string tag;
    srcSel = sel;
    extPin = pin;
    case (sel)
      3'b000:  begin e = 1'b0;                  tag = "R1"; end
      3'b001:  begin e = 1'b1;                  tag = "R2"; end
      3'b010:  begin e = (edgeCnt % 8 == 0);    tag = "R3 R4"; end
      3'b011:  begin e = (edgeCnt % 64 == 0);   tag = "R3 R4"; end
      3'b100:  begin e = (edgeCnt % 256 == 0);  tag = "R3 R4"; end
      3'b101:  begin e = (edgeCnt % 1024 == 0); tag = "R3 R4"; end
      3'b110:  begin e = h3 & ~h2;              tag = "R5 R6"; end
      default: begin e = h2 & ~h3;              tag = "R5 R6"; end
    endcase
    if (sel != lastSel) tag = {tag, " R7"};
    expQ.push_back(e);
    tagQ.push_back(tag);
    h3 = h2; h2 = h1; h1 = pin;
    lastSel = sel;
    edgeCnt++;
    @(negedge clk);
  endtask

  task automatic run(input logic [2:0] sel, input int n);
    for (int i = 0; i < n; i++) step(sel, extPin);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    #1;
    checks++;
    if (cntEn !== 1'b0) begin
      fails++;
      $display("FAIL R8 reset: cntEn=%b expected 0", cntEn);
    end
    edgeCnt = 0; h1 = 0; h2 = 0; h3 = 0;
    extPin = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // Monitor: pop one expectation per rising edge, sampled just after it.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        logic  e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if (cntEn !== e) begin
          fails++;
          $display("FAIL %s at t=%0t: cntEn=%b expected %b", t, $time, cntEn, e);
        end
      end
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset();                       // R8 initial reset
    run(3'b000, 20);                 // R1
    run(3'b001, 20);                 // R2
    run(3'b010, 40);                 // R3 divide by 8
    run(3'b011, 150);                // R3 divide by 64
    run(3'b100, 600);                // R4: count keeps running across the switch
    run(3'b101, 2100);               // R3 divide by 1024
    // R5 rising edges, with pulses of different widths
    for (int k = 0; k < 6; k++) begin
      step(3'b111, 1'b1);
      for (int j = 0; j < k + 2; j++) step(3'b111, 1'b1);
      for (int j = 0; j < 4; j++) step(3'b111, 1'b0);
    end
    // R5 falling edges, toggling every other cycle
    for (int k = 0; k < 8; k++) begin
      step(3'b110, 1'b1);
      step(3'b110, 1'b1);
      step(3'b110, 1'b0);
      step(3'b110, 1'b0);
    end
    // R6: pin rises while stopped, then rising mode picks it up
    step(3'b000, 1'b0);
    step(3'b000, 1'b1);
    step(3'b111, 1'b1);
    step(3'b111, 1'b1);
    step(3'b111, 1'b1);
    step(3'b111, 1'b0);
    // R7: a new code every cycle
    for (int k = 0; k < 64; k++) step(3'((k * 5) % 8), 1'(k % 3 == 0));
    // R8: mid-run reset, then prescale count restarts at 0
    doReset();
    run(3'b010, 30);
    run(3'b011, 70);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule